// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit sits in the address stage of a 32-bit load/store pipeline. For each accepted operation it forms two results from a base register value and an offset. The first is the address used by the current memory access. The second is an updated base value, together with an enable that says whether the register file should take it. The offset is either a 12-bit immediate magnitude or a second register value. A register offset can pass through a barrel shifter first, and either kind of offset is added to or subtracted from the base.

Two addressing orders are available. In pre-indexed operation the access uses the adjusted base, and writing that adjusted base back is optional. In post-indexed operation the access uses the unmodified base, and the adjusted base is always written back. This lets software walk an array either from its first element or from its second. Results pass through one registered stage with a valid/ready handshake on each side.

Top module: `agu_top`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, out_valid_o is 0 and in_ready_o is 1.
- R2: With post_i=0 and use_reg_i=0, addr_o equals base_i plus the zero-extended imm_i when sub_i=0, and base_i minus it when sub_i=1, modulo 2^32. An imm_i of 0 gives base_i.
- R3: With post_i=0, wb_data_o equals addr_o. wb_en_o equals wback_i.
- R4: With post_i=1, addr_o equals base_i and wb_data_o equals base_i plus or minus the offset. wb_en_o is 1 whatever wback_i holds.
- R5: With use_reg_i=1 the offset is offs_reg_i after shifting. sub_i=0 adds it to base_i and sub_i=1 subtracts it, in both pre- and post-indexed forms.
- R6: shift_kind_i selects the shift applied to offs_reg_i by shift_amt_i (0 to 31): 0 is logical left, 1 is logical right, 2 is arithmetic right, 3 is rotate right.
- R7: A shift_amt_i of 0 passes offs_reg_i through unchanged for every shift_kind_i.
- R8: With use_reg_i=0, offs_reg_i, shift_kind_i and shift_amt_i have no effect on any output.
- R9: in_ready_o is 1 exactly when out_valid_o is 0 or out_ready_i is 1. While out_valid_o=1 and out_ready_i=0, out_valid_o, addr_o, wb_data_o and wb_en_o hold their values. Results leave in the order the operations were accepted.
- R10: Post-indexed operations with immediate 4, each fed the previous wb_data_o as its base, access base, base+4 and base+8. Pre-indexed operations with writeback, fed the same way, access base+4, base+8 and base+12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Operation accepted this cycle when high with in_valid_i |
| base_i | input | 32 | Base register value |
| offs_reg_i | input | 32 | Offset register value |
| imm_i | input | 12 | Immediate offset magnitude |
| use_reg_i | input | 1 | 1: register offset, 0: immediate offset |
| sub_i | input | 1 | 1: subtract offset, 0: add offset |
| post_i | input | 1 | 1: post-indexed, 0: pre-indexed |
| wback_i | input | 1 | Writeback request for pre-indexed operations |
| shift_kind_i | input | 2 | Register offset shift type |
| shift_amt_i | input | 5 | Register offset shift amount |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Consumer takes result |
| addr_o | output | 32 | Access address |
| wb_data_o | output | 32 | Updated base value |
| wb_en_o | output | 1 | Base register writeback enable |

## Verification
Immediate offsets are applied with addition and subtraction, at zero and at values that wrap past 0 and 2^32. This separates correct modular arithmetic from sign and carry mistakes. The same base and offset are then run through pre-indexed operation with and without writeback and through post-indexed operation, which shows whether the access address and the updated base come from the right source. A register holding a value with both its top and bottom bits set is shifted with every shift kind at non-zero and zero amounts, which shows any mix-up between the kinds or any sign-fill fault. Chained walks and a long random mix run under random output stalls, which shows ordering faults and whether outputs hold while stalled.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int unsigned XLEN  = 32;
  localparam int unsigned IMM_W = 12;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;

  typedef struct packed {
    logic [XLEN-1:0] addr;
    logic [XLEN-1:0] wb_data;
    logic            wb_en;
  } agu_result_t;
endpackage

// File: rtl/agu_shifter.sv
module agu_shifter
  import agu_pkg::*;
#(
  parameter int unsigned W   = XLEN,
  parameter int unsigned SHW = $clog2(W)
) (
  input  logic [W-1:0]   val_i,
  input  shift_kind_e    kind_i,
  input  logic [SHW-1:0] amt_i,
  output logic [W-1:0]   res_o
);
  logic [W-1:0] stage [SHW+1];

  assign stage[0] = val_i;

  // log-depth barrel: stage k shifts by 2**k when amount bit k is set
  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int unsigned S = 2 ** k;
    logic [W-1:0] shifted;
    always_comb begin
      unique case (kind_i)
        SH_LSL:  shifted = stage[k] << S;
        SH_LSR:  shifted = stage[k] >> S;
        SH_ASR:  shifted = W'($signed(stage[k]) >>> S);
        default: shifted = (stage[k] >> S) | (stage[k] << (W - S));
      endcase
    end
    assign stage[k+1] = amt_i[k] ? shifted : stage[k];
  end

  assign res_o = stage[SHW];

  always_comb begin
    if (amt_i == '0) begin
      assert_zero_passthru_R7: assert (res_o == val_i);
    end
    if (kind_i == SH_LSL) begin
      assert_lsl_match_R6: assert (res_o == (val_i << amt_i));
    end
  end
endmodule

// File: rtl/agu_offset_gen.sv
module agu_offset_gen
  import agu_pkg::*;
#(
  parameter int unsigned W   = XLEN,
  parameter int unsigned IW  = IMM_W,
  parameter int unsigned SHW = $clog2(W)
) (
  input  logic [W-1:0]   reg_i,
  input  logic [IW-1:0]  imm_i,
  input  logic           use_reg_i,
  input  shift_kind_e    kind_i,
  input  logic [SHW-1:0] amt_i,
  output logic [W-1:0]   offs_o
);
  logic [W-1:0] reg_shifted;

  agu_shifter #(.W(W), .SHW(SHW)) u_shift (
    .val_i  (reg_i),
    .kind_i (kind_i),
    .amt_i  (amt_i),
    .res_o  (reg_shifted)
  );

  assign offs_o = use_reg_i ? reg_shifted : {{(W-IW){1'b0}}, imm_i};

  always_comb begin
    if (!use_reg_i) begin
      assert_imm_isolated_R8: assert (offs_o[W-1:IW] == '0);
    end
  end
endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
  import agu_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] offs_i,
  input  logic         sub_i,
  input  logic         post_i,
  input  logic         wback_i,
  output logic [W-1:0] addr_o,
  output logic [W-1:0] upd_o,
  output logic         wb_en_o
);
  // single adder: subtract as add of the inverted offset with carry-in
  logic [W-1:0] opnd;
  assign opnd    = sub_i ? ~offs_i : offs_i;
  assign upd_o   = base_i + opnd + W'(sub_i);
  assign addr_o  = post_i ? base_i : upd_o;
  assign wb_en_o = post_i | wback_i;
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int unsigned W   = XLEN,
  parameter int unsigned IW  = IMM_W,
  parameter int unsigned SHW = $clog2(W)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_valid_i,
  output logic           in_ready_o,
  input  logic [W-1:0]   base_i,
  input  logic [W-1:0]   offs_reg_i,
  input  logic [IW-1:0]  imm_i,
  input  logic           use_reg_i,
  input  logic           sub_i,
  input  logic           post_i,
  input  logic           wback_i,
  input  logic [1:0]     shift_kind_i,
  input  logic [SHW-1:0] shift_amt_i,
  output logic           out_valid_o,
  input  logic           out_ready_i,
  output logic [W-1:0]   addr_o,
  output logic [W-1:0]   wb_data_o,
  output logic           wb_en_o
);
  logic [W-1:0] offs, addr_d, upd_d;
  logic         wb_en_d, accept;
  logic         valid_q;
  logic [W-1:0] addr_q, wb_q;
  logic         wb_en_q;

  agu_offset_gen #(.W(W), .IW(IW), .SHW(SHW)) u_offs (
    .reg_i     (offs_reg_i),
    .imm_i     (imm_i),
    .use_reg_i (use_reg_i),
    .kind_i    (shift_kind_e'(shift_kind_i)),
    .amt_i     (shift_amt_i),
    .offs_o    (offs)
  );

  agu_addr_calc #(.W(W)) u_calc (
    .base_i  (base_i),
    .offs_i  (offs),
    .sub_i   (sub_i),
    .post_i  (post_i),
    .wback_i (wback_i),
    .addr_o  (addr_d),
    .upd_o   (upd_d),
    .wb_en_o (wb_en_d)
  );

  assign in_ready_o = !valid_q || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
    end else if (accept) begin
      valid_q <= 1'b1;
    end else if (out_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  // data flops carry no reset; qualified by valid_q
  always_ff @(posedge clk_i) begin
    if (accept) begin
      addr_q  <= addr_d;
      wb_q    <= upd_d;
      wb_en_q <= wb_en_d;
    end
  end

  assign out_valid_o = valid_q;
  assign addr_o      = addr_q;
  assign wb_data_o   = wb_q;
  assign wb_en_o     = wb_en_q;

  assert_hold_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(addr_o) && $stable(wb_data_o) && $stable(wb_en_o)));

  assert_post_base_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && post_i) |=> (addr_o == $past(base_i) && wb_en_o));

  assert_pre_wb_value_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && !post_i) |=> (addr_o == wb_data_o));

  assert_pre_wb_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && !post_i) |=> (wb_en_o == $past(wback_i)));

  assert_accept_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);
endmodule

// File: tb/agu_top_tb_top.sv
`timescale 1ns/1ps
module agu_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] base_i = '0, offs_reg_i = '0;
  logic [11:0] imm_i = '0;
  logic        use_reg_i = 1'b0, sub_i = 1'b0, post_i = 1'b0, wback_i = 1'b0;
  logic [1:0]  shift_kind_i = '0;
  logic [4:0]  shift_amt_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [31:0] addr_o, wb_data_o;
  logic        wb_en_o;

  always #2.5 clk_i = ~clk_i;

  agu_top dut_i (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .base_i, .offs_reg_i, .imm_i,
    .use_reg_i, .sub_i, .post_i, .wback_i, .shift_kind_i, .shift_amt_i,
    .out_valid_o, .out_ready_i, .addr_o, .wb_data_o, .wb_en_o
  );

  typedef struct {
    logic [31:0] addr;
    logic [31:0] wb;
    logic        en;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   stall_en = 1'b0;
  bit   done     = 1'b0;

  function automatic logic [31:0] ref_shift(logic [31:0] v, logic [1:0] k, logic [4:0] a);
    if (a == 0) return v;
    case (k)
      2'd0:    return v << a;
      2'd1:    return v >> a;
      2'd2:    return $signed(v) >>> a;
      default: return (v >> a) | (v << (6'd32 - {1'b0, a}));
    endcase
  endfunction

  function automatic exp_t model(logic [31:0] b, logic [31:0] r, logic [11:0] im,
                                 logic ur, logic sb, logic po, logic wb,
                                 logic [1:0] k, logic [4:0] a, string tag);
    exp_t e;
    logic [31:0] off, upd;
    off   = ur ? ref_shift(r, k, a) : {20'd0, im};
    upd   = sb ? b - off : b + off;
    e.addr = po ? b : upd;
    e.wb   = upd;
    e.en   = po | wb;
    e.tag  = tag;
    return e;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic send(logic [31:0] b, logic [31:0] r, logic [11:0] im, logic ur, logic sb,
                      logic po, logic wb, logic [1:0] k, logic [4:0] a, string tag);
    @(negedge clk_i);
    base_i = b; offs_reg_i = r; imm_i = im; use_reg_i = ur; sub_i = sb;
    post_i = po; wback_i = wb; shift_kind_i = k; shift_amt_i = a;
    in_valid_i = 1'b1;
    #1;
    while (!in_ready_o) begin
      @(negedge clk_i);
      #1;
    end
    sb_q.push_back(model(b, r, im, ur, sb, po, wb, k, a, tag));
  endtask

  task automatic idle();
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((sb_q.size() != 0 || out_valid_o) && guard < 1000) begin
      @(negedge clk_i);
      guard++;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // output stall generator
  always @(negedge clk_i) begin
    out_ready_i <= stall_en ? (($urandom % 4) != 0) : 1'b1;
  end

  // monitor: pops expected items on each transfer, checks hold while stalled
  logic        p_stall = 1'b0;
  logic [31:0] p_addr, p_wb;
  logic        p_en;
  always @(negedge clk_i) begin
    #2;
    if (rst_ni) begin
      if (p_stall) begin
        check(out_valid_o && addr_o == p_addr && wb_data_o == p_wb && wb_en_o == p_en,
              "R9", "hold", addr_o, p_addr);
      end
      if (out_valid_o && out_ready_i) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R9", "unexpected output", addr_o, 32'h0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(addr_o == e.addr, e.tag, "addr", addr_o, e.addr);
          check(wb_data_o == e.wb, e.tag, "wb_data", wb_data_o, e.wb);
          check(wb_en_o == e.en, e.tag, "wb_en", {31'd0, wb_en_o}, {31'd0, e.en});
        end
      end
      check(in_ready_o == (!out_valid_o || out_ready_i), "R9", "in_ready",
            {31'd0, in_ready_o}, {31'd0, (!out_valid_o || out_ready_i)});
      p_stall = out_valid_o && !out_ready_i;
      p_addr  = addr_o;
      p_wb    = wb_data_o;
      p_en    = wb_en_o;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", sb_q.size(), 0);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] wb;
    repeat (3) @(negedge clk_i);
    #1;
    check(!out_valid_o, "R1", "out_valid in reset", {31'd0, out_valid_o}, 32'd0);
    check(in_ready_o, "R1", "in_ready in reset", {31'd0, in_ready_o}, 32'd1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check(!out_valid_o, "R1", "out_valid after reset", {31'd0, out_valid_o}, 32'd0);
    check(in_ready_o, "R1", "in_ready after reset", {31'd0, in_ready_o}, 32'd1);

    // R2 pre-indexed immediate
    send(32'h0000_1000, 0, 12'h010, 0, 0, 0, 0, 0, 0, "R2");
    send(32'h0000_1000, 0, 12'h000, 0, 0, 0, 0, 0, 0, "R2");
    send(32'h0000_0010, 0, 12'h020, 0, 1, 0, 0, 0, 0, "R2");
    send(32'hFFFF_FFFC, 0, 12'h008, 0, 0, 0, 0, 0, 0, "R2");
    send(32'h0000_2000, 0, 12'hFFF, 0, 1, 0, 0, 0, 0, "R2");
    // R3 pre-indexed writeback
    send(32'h0000_4000, 0, 12'h00C, 0, 0, 0, 1, 0, 0, "R3");
    send(32'h0000_4000, 0, 12'h00C, 0, 1, 0, 0, 0, 0, "R3");
    // R4 post-indexed, wback ignored
    send(32'h0000_4000, 0, 12'h00C, 0, 0, 1, 0, 0, 0, "R4");
    send(32'h0000_4000, 0, 12'h00C, 0, 1, 1, 1, 0, 0, "R4");
    // R5 register offset add/sub, pre and post
    send(32'h0001_0000, 32'h0000_0123, 0, 1, 0, 0, 1, 0, 0, "R5");
    send(32'h0001_0000, 32'h0000_0123, 0, 1, 1, 0, 0, 0, 0, "R5");
    send(32'h0001_0000, 32'h0000_0001, 0, 1, 0, 1, 0, 0, 2, "R5");
    send(32'h0001_0000, 32'h0000_0002, 0, 1, 1, 1, 0, 0, 2, "R5");
    // R6 shift kinds
    for (int k = 0; k < 4; k++) begin
      send(32'h0, 32'h8000_0011, 0, 1, 0, 0, 0, k[1:0], 5'd4, "R6");
      send(32'h0, 32'h8000_0011, 0, 1, 0, 0, 0, k[1:0], 5'd31, "R6");
    end
    // R7 zero amount
    for (int k = 0; k < 4; k++) begin
      send(32'h100, 32'h8000_0011, 0, 1, 0, 0, 0, k[1:0], 5'd0, "R7");
    end
    // R8 immediate ignores register and shift controls
    send(32'h500, 32'hDEAD_BEEF, 12'h004, 0, 0, 0, 1, 2'd3, 5'd7, "R8");
    send(32'h500, 32'h1234_5678, 12'h004, 0, 1, 1, 0, 2'd2, 5'd31, "R8");
    idle();
    drain();

    // R10 chained walks: base taken from previous wb_data of the bench model
    wb = 32'h0000_8000;
    for (int i = 0; i < 3; i++) begin
      check(model(wb, 0, 12'd4, 0, 0, 1, 0, 0, 0, "R10").addr == 32'h8000 + 32'(4 * i),
            "R10", "post walk model", wb, 32'h8000 + 32'(4 * i));
      send(wb, 0, 12'd4, 0, 0, 1, 0, 0, 0, "R10");
      wb = wb + 32'd4;
    end
    wb = 32'h0000_8000;
    for (int i = 0; i < 3; i++) begin
      send(wb, 0, 12'd4, 0, 0, 0, 1, 0, 0, "R10");
      wb = wb + 32'd4;
    end
    idle();
    drain();

    // R9 random mix under output stalls
    stall_en = 1'b1;
    for (int i = 0; i < 300; i++) begin
      send($urandom, $urandom, 12'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 2'($urandom), 5'($urandom), "R9");
      if (($urandom % 5) == 0) idle();
    end
    idle();
    drain();
    stall_en = 1'b0;
    repeat (2) @(negedge clk_i);
    check(sb_q.size() == 0, "R9", "scoreboard empty", sb_q.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule